// File: doc/BRIEF.md
# Fast-Clock Buffer Occupancy Tracker

This block holds the fill level of a buffer as one up/down register clocked only by the fast read clock. The writing side runs on a much slower, unrelated clock and deposits a burst of words on each of its write cycles. Its write-enable level enters this block directly. Inside, the block passes it through a chain of synchronizer flops and turns the chosen edge into a pulse one fast cycle wide. The reader issues a one-cycle read strobe for every word it removes.

The level output is the number of words held, which is the write count minus the read count. It comes straight from the register, so no cross-domain comparison of two address counters and no subtractor is needed. The block also derives an empty flag and a full flag from the level. The full flag warns that another burst would not fit. A sticky overflow flag records any burst that arrived while the buffer was full.

Top module: `occupancy_tracker`

## Requirements
- R1: A synchronous reset (rst high at a rising clk edge) clears level to 0 and overflow to 0, drives empty to 1 and full to 0, and clears the synchronizer so no stale event follows.
- R2: A 0-to-1 change of wr_en_slow is one write event. The level rises by BURST (default 4) on the third rising clk edge after wr_en_slow changes (SYNC_STAGES + 1 edges, default 2 + 1). The input may stay high for any number of cycles and still adds only once.
- R3: A read strobe while level is above 0 lowers the level by 1 at the next rising edge.
- R4: A read strobe while level is 0 is ignored, and the level stays 0.
- R5: When an accepted write event and an accepted read land in the same cycle, the level changes by BURST - 1 (+3 by default).
- R6: empty is 1 exactly when level is 0. full is 1 exactly when level is greater than DEPTH - BURST.
- R7: A write event that arrives while full is 1 is ignored and sets overflow. overflow stays 1 until reset. A read in that same cycle is still taken.
- R8: The level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast read-side clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_slow | input | 1 | Write-enable level from the slow domain, asynchronous to clk |
| rd_stb | input | 1 | One-cycle read strobe, one word per cycle |
| level | output | $clog2(DEPTH+1) | Words currently held |
| empty | output | 1 | Level is zero |
| full | output | 1 | Another burst would not fit |
| overflow | output | 1 | Sticky: a burst was dropped |

## Verification
Read and reset effects are due one rising edge after the cycle that carries them. A write event is due three edges after wr_en_slow moves: two synchronizer flops and then the level register. The bench keeps its own three-deep history of the wr_en_slow values it applied, and uses the entry from two edges back to decide whether an event lands on the coming edge. It changes inputs only on falling edges and compares every output on the falling edge after each rising edge, so each expected value is compared in the cycle it is due.

// File: rtl/occ_pkg.sv
package occ_pkg;

   // Which transition of the synchronized write enable counts as an event
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   // Qualified update request presented to the level register
   typedef struct packed {
      logic add;   // accepted burst
      logic sub;   // accepted single-word read
      logic drop;  // burst refused because full
   } occ_req_t;

endpackage

// File: rtl/occ_evt_sync.sv
module occ_evt_sync #(
   parameter int                  SYNC_STAGES = 2,
   parameter occ_pkg::edge_sel_e  EDGE        = occ_pkg::EDGE_RISE
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic evt_pulse
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("occ_evt_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sh_q;
   logic                   prev_q;
   logic                   sync_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[SYNC_STAGES-2:0], async_in};
         prev_q <= sync_bit;
      end
   end

   assign sync_bit = sh_q[SYNC_STAGES-1];

   generate
      if (EDGE == occ_pkg::EDGE_RISE) begin : g_rise
         assign evt_pulse = sync_bit & ~prev_q;
      end else begin : g_fall
         assign evt_pulse = ~sync_bit & prev_q;
      end
   endgenerate

   // R2
   evt_single_chk: assert property (@(posedge clk) disable iff (rst)
      evt_pulse |=> !evt_pulse)
      else $error("event pulse longer than one cycle");

endmodule

// File: rtl/occ_flags.sv
module occ_flags #(
   parameter int DEPTH = 64,
   parameter int BURST = 4,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full
);

   localparam int HEADROOM = DEPTH - BURST;

   always_comb begin
      empty = (level == '0);
      full  = (int'({1'b0, level}) > HEADROOM);
   end

endmodule

// File: rtl/occ_level_core.sv
module occ_level_core #(
   parameter int DEPTH = 64,
   parameter int BURST = 4,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_evt,
   input  logic             rd_stb,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             overflow
);

   localparam logic [LVL_W-1:0] BURST_V = LVL_W'(BURST);
   localparam logic [LVL_W-1:0] NET_V   = LVL_W'(BURST - 1);

   occ_pkg::occ_req_t req;
   logic [LVL_W-1:0]  lvl_q;
   logic [LVL_W-1:0]  lvl_d;
   logic              ovf_q;

   occ_flags #(.DEPTH(DEPTH), .BURST(BURST), .LVL_W(LVL_W)) u_flags (
      .level (lvl_q),
      .empty (empty),
      .full  (full)
   );

   always_comb begin
      req.add  = wr_evt & ~full;
      req.drop = wr_evt &  full;
      req.sub  = rd_stb & ~empty;
      lvl_d    = lvl_q;
      if (req.add)
         lvl_d = lvl_d + BURST_V;
      if (req.sub)
         lvl_d = lvl_d - LVL_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         lvl_q <= lvl_d;
         if (req.drop)
            ovf_q <= 1'b1;
      end
   end

   assign level    = lvl_q;
   assign overflow = ovf_q;

   // R8
   level_cap_chk: assert property (@(posedge clk) disable iff (rst)
      int'({1'b0, level}) <= DEPTH)
      else $error("level above depth");

   // R4
   rd_empty_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && empty && !wr_evt) |=> (level == '0))
      else $error("read on empty changed level");

   // R5
   both_net_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_evt && rd_stb && !full && !empty) |=> (level == $past(level) + NET_V))
      else $error("coincident write/read wrong step");

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow)
      else $error("overflow flag not sticky");

   // R7
   full_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_evt && full && !rd_stb) |=> ($stable(level) && overflow))
      else $error("write while full not dropped");

   // R3
   rd_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && !empty && !wr_evt) |=> (level == $past(level) - LVL_W'(1)))
      else $error("read did not remove one word");

endmodule

// File: rtl/occupancy_tracker.sv
module occupancy_tracker #(
   parameter int                 DEPTH       = 64,
   parameter int                 BURST       = 4,
   parameter int                 SYNC_STAGES = 2,
   parameter occ_pkg::edge_sel_e EDGE        = occ_pkg::EDGE_RISE,
   parameter int                 LVL_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en_slow,
   input  logic             rd_stb,
   output logic [LVL_W-1:0] level,
   output logic             empty,
   output logic             full,
   output logic             overflow
);

   generate
      if (BURST < 1 || DEPTH < BURST) begin : g_bad_depth
         $error("occupancy_tracker: need 1 <= BURST <= DEPTH");
      end
      if (LVL_W < $clog2(DEPTH + 1)) begin : g_bad_width
         $error("occupancy_tracker: LVL_W too narrow for DEPTH");
      end
   endgenerate

   logic wr_evt;

   occ_evt_sync #(.SYNC_STAGES(SYNC_STAGES), .EDGE(EDGE)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .async_in  (wr_en_slow),
      .evt_pulse (wr_evt)
   );

   occ_level_core #(.DEPTH(DEPTH), .BURST(BURST), .LVL_W(LVL_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .wr_evt   (wr_evt),
      .rd_stb   (rd_stb),
      .level    (level),
      .empty    (empty),
      .full     (full),
      .overflow (overflow)
   );

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (level == '0 && empty && !full && !overflow))
      else $error("reset did not clear state");

endmodule

// File: tb/sim_occupancy_tracker.sv
`timescale 1ns/1ps
module sim_occupancy_tracker;

   localparam int DEPTH = 16;
   localparam int BURST = 4;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst;
   logic             wr_en_slow;
   logic             rd_stb;
   logic [LVL_W-1:0] level;
   logic             empty, full, overflow;

   int checks = 0;
   int errors = 0;
   int exp_lvl = 0;
   logic exp_ovf = 1'b0;
   logic p1 = 1'b0, p2 = 1'b0, p3 = 1'b0;  // wr_en_slow at the last three edges
   bit done = 1'b0;

   always #10 clk = ~clk;

   occupancy_tracker #(.DEPTH(DEPTH), .BURST(BURST)) u0 (
      .clk(clk), .rst(rst), .wr_en_slow(wr_en_slow), .rd_stb(rd_stb),
      .level(level), .empty(empty), .full(full), .overflow(overflow)
   );

   function automatic bit exp_full(input int l);
      return l > DEPTH - BURST;
   endfunction

   function automatic int next_level(input int l, input bit ev, input bit rd);
      int n = l;
      if (ev && !exp_full(l)) n += BURST;
      if (rd && l > 0) n -= 1;
      return n;
   endfunction

   task automatic check_all(input string tag);
      checks++;
      if (int'(level) != exp_lvl || empty != (exp_lvl == 0) ||
          full != exp_full(exp_lvl) || overflow != exp_ovf) begin
         errors++;
         $display("FAIL %s: level=%0d empty=%0b full=%0b ovf=%0b expected level=%0d empty=%0b full=%0b ovf=%0b",
                  tag, level, empty, full, overflow, exp_lvl, exp_lvl == 0,
                  exp_full(exp_lvl), exp_ovf);
      end
   endtask

   task automatic check_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Called at a falling edge: apply inputs, advance one edge, compare.
   task automatic step(input bit w, input bit r);
      bit ev;
      string tag;
      wr_en_slow = w;
      rd_stb     = r;
      ev = p2 && !p3;
      if (ev && exp_full(exp_lvl))        tag = "R7";
      else if (ev && r && exp_lvl > 0)    tag = "R5";
      else if (r && exp_lvl == 0)         tag = "R4";
      else if (ev)                        tag = "R2";
      else if (r)                         tag = "R3";
      else                                tag = "R6";
      if (ev && exp_full(exp_lvl)) exp_ovf = 1'b1;
      @(posedge clk);
      exp_lvl = next_level(exp_lvl, ev, r);
      p3 = p2; p2 = p1; p1 = w;
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic do_reset();
      rst = 1'b1; wr_en_slow = 1'b0; rd_stb = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      exp_lvl = 0; exp_ovf = 1'b0; p1 = 1'b0; p2 = 1'b0; p3 = 1'b0;
   endtask

   task automatic burst_write();
      step(1, 0); step(1, 0); step(1, 0); step(0, 0); step(0, 0);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      check_all("R1");

      // R2: held enable adds exactly one burst
      repeat (6) step(1, 0);
      check_val("R2", int'(level), 4);
      step(0, 0); step(0, 0);

      // R3 then R4: drain past empty
      repeat (6) step(0, 1);
      check_val("R4", int'(level), 0);

      // R5: event coincides with a read at non-zero level
      burst_write();
      step(1, 0); step(1, 0); step(1, 1); step(0, 0);
      check_val("R5", int'(level), 7);

      // R6, R7, R8: fill until bursts are refused
      repeat (4) burst_write();
      check_val("R6", int'(full), 1);
      check_val("R7", int'(overflow), 1);
      check_val("R8", int'(level <= DEPTH), 1);

      // R7: read in the refused-burst cycle still taken
      step(1, 0); step(1, 0); step(1, 1); step(0, 0);

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         bit w, r;
         w = ($urandom % 3 == 0) ? ~wr_en_slow : wr_en_slow;
         r = ($urandom % 2) == 1;
         step(w, r);
      end

      // R1: reset clears sticky overflow
      do_reset();
      check_all("R1");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule